// File: doc/BRIEF.md
# Cartridge Bank Switching Decoder

This block is the address-mapping front end of a game cartridge controller. The CPU programs it by writing to the upper half of its address space. Only the low four address bits select a register, so the sixteen registers repeat through all of $8000-$FFFF. Eight registers each hold the bank number for one 1 KiB slice of the character space. One register holds the bank number for the switchable 16 KiB program window. One register holds a 2-bit nametable arrangement code. The remaining six indices belong to functions outside this block, and writes to them are discarded here.

On every clock the block takes the current CPU address and the current PPU address. It registers three results: the program ROM address, the character ROM address and the nametable page-select line. The lower program window at CPU $8000-$BFFF follows the programmed bank. The upper window at $C000-$FFFF is always the last bank. A register write and an address translation may occur in the same cycle. In that case the translation uses the bank values that were held before the write.

Top module: `cart_bank_map`

## Requirements
- R1: A register write happens on a clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1. The register index is `cpu_addr[3:0]`, and address bits 14 to 4 have no influence on which register is written.
- R2: Indices 0 to 7 store `cpu_data` (CHR_BANK_W bits) as the bank number of character slot n. Slot n covers PPU addresses n*$400 to n*$400+$3FF.
- R3: Index 8 stores `cpu_data[PRG_BANK_W-1:0]` as the program bank used when `cpu_addr[14]` is 0, which is the $8000-$BFFF window.
- R4: When `cpu_addr[14]` is 1 (the $C000-$FFFF window), the program bank field of `prg_addr` is all ones, whatever the index 8 register holds.
- R5: `prg_addr` equals {bank, cpu_addr[13:0]}.
- R6: `chr_addr` equals {bank of slot ppu_addr[12:10], ppu_addr[9:0]}.
- R7: Index 9 stores `cpu_data[1:0]` as the mirroring code. The code sets `nt_page` as follows: 0 gives `ppu_addr[10]`, 1 gives `ppu_addr[11]`, 2 gives constant 0, and 3 gives constant 1.
- R8: Writes to indices 10 to 15 leave every bank and mode register unchanged. So do writes with `cpu_addr[15]` at 0.
- R9: A synchronous active-high `rst` clears every bank register and the mirroring code. While `rst` is held, it also clears all three outputs to zero.
- R10: The outputs are registered. They reflect the addresses of the previous cycle and the register contents from before that edge. A write therefore first shows in the translation of the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| ppu_addr | input | 14 | PPU address bus |
| prg_addr | output | PRG_BANK_W+14 | Translated program ROM address |
| chr_addr | output | CHR_BANK_W+10 | Translated character ROM address |
| nt_page | output | 1 | Nametable page select |

## Verification
The critical overlap is a register write arriving in the same cycle as a translation through the register being written. It occurs, for example, when a write to index 8 targets an address in the lower program window, or when a write to a character slot coincides with a PPU fetch from that slot. The bench provokes this deliberately: in one directed step the CPU address of the bank write is itself the address being translated. The result of that step must carry the old bank, and the step after it must carry the new one. A long random phase then issues writes and fetches together on every clock, and a cycle-accurate behavioural model judges each output.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int IDX_W     = 4;
  localparam int CHR_SLOTS = 8;
  localparam int SLOT_SEL_W = $clog2(CHR_SLOTS);
  localparam int PRG_OFF_W = 14;
  localparam int CHR_OFF_W = 10;
  localparam logic [IDX_W-1:0] IDX_PRG = 4'd8;
  localparam logic [IDX_W-1:0] IDX_MIR = 4'd9;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mir_mode_e;
endpackage

// File: rtl/cart_reg_file.sv
module cart_reg_file
  import cart_map_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    wr_en,
  input  logic [IDX_W-1:0]                        idx,
  input  logic [7:0]                              data,
  output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]    chr_bank,
  output logic [PRG_BANK_W-1:0]                   prg_bank,
  output mir_mode_e                               mode
);
  logic unused_data;
  assign unused_data = ^data;

  // one register per character slot
  for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_slot
    logic [CHR_BANK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && idx == IDX_W'(s))
        q <= data[CHR_BANK_W-1:0];
    end
    assign chr_bank[s] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      prg_bank <= '0;
    else if (wr_en && idx == IDX_PRG)
      prg_bank <= data[PRG_BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode <= MIR_VERT;
    else if (wr_en && idx == IDX_MIR)
      mode <= mir_mode_e'(data[1:0]);
  end
endmodule

// File: rtl/cart_prg_xlat.sv
module cart_prg_xlat
  import cart_map_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  localparam int PRG_AW = PRG_BANK_W + PRG_OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRG_OFF_W:0]    cpu_off,
  input  logic [PRG_BANK_W-1:0] prg_bank,
  output logic [PRG_AW-1:0]     prg_addr
);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

  logic [PRG_BANK_W-1:0] bank_sel;
  assign bank_sel = cpu_off[PRG_OFF_W] ? LAST_BANK : prg_bank;

  always_ff @(posedge clk) begin
    if (rst) prg_addr <= '0;
    else     prg_addr <= {bank_sel, cpu_off[PRG_OFF_W-1:0]};
  end
endmodule

// File: rtl/cart_chr_xlat.sv
module cart_chr_xlat
  import cart_map_pkg::*;
#(
  parameter int CHR_BANK_W = 8,
  localparam int CHR_AW = CHR_BANK_W + CHR_OFF_W
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [CHR_OFF_W+SLOT_SEL_W-1:0]      ppu_off,
  input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank,
  output logic [CHR_AW-1:0]                    chr_addr
);
  logic [SLOT_SEL_W-1:0] slot;
  assign slot = ppu_off[CHR_OFF_W +: SLOT_SEL_W];

  always_ff @(posedge clk) begin
    if (rst) chr_addr <= '0;
    else     chr_addr <= {chr_bank[slot], ppu_off[CHR_OFF_W-1:0]};
  end
endmodule

// File: rtl/cart_nt_sel.sv
module cart_nt_sel
  import cart_map_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] ppu_nt,
  input  mir_mode_e mode,
  output logic      nt_page
);
  logic page_d;
  always_comb begin
    unique case (mode)
      MIR_VERT:   page_d = ppu_nt[0];
      MIR_HORZ:   page_d = ppu_nt[1];
      MIR_ONE_LO: page_d = 1'b0;
      default:    page_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) nt_page <= 1'b0;
    else     nt_page <= page_d;
  end
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cart_map_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 8,
  localparam int PRG_AW = PRG_BANK_W + PRG_OFF_W,
  localparam int CHR_AW = CHR_BANK_W + CHR_OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic [13:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              nt_page
);
  logic                                 reg_wr;
  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank_q;
  logic [PRG_BANK_W-1:0]                prg_bank_q;
  mir_mode_e                            mode_q;
  logic                                 unused_ppu_hi;

  assign reg_wr        = cpu_wr & cpu_addr[15];
  assign unused_ppu_hi = ppu_addr[13];

  cart_reg_file #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .idx      (cpu_addr[IDX_W-1:0]),
    .data     (cpu_data),
    .chr_bank (chr_bank_q),
    .prg_bank (prg_bank_q),
    .mode     (mode_q)
  );

  cart_prg_xlat #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .cpu_off  (cpu_addr[PRG_OFF_W:0]),
    .prg_bank (prg_bank_q),
    .prg_addr (prg_addr)
  );

  cart_chr_xlat #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .clk      (clk),
    .rst      (rst),
    .ppu_off  (ppu_addr[CHR_OFF_W+SLOT_SEL_W-1:0]),
    .chr_bank (chr_bank_q),
    .chr_addr (chr_addr)
  );

  cart_nt_sel u_nt (
    .clk     (clk),
    .rst     (rst),
    .ppu_nt  (ppu_addr[11:10]),
    .mode    (mode_q),
    .nt_page (nt_page)
  );
endmodule

// File: rtl/cart_bank_map_chk.sv
module cart_bank_map_chk #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [15:0]                  cpu_addr,
  input logic [7:0]                   cpu_data,
  input logic                         cpu_wr,
  input logic [13:0]                  ppu_addr,
  input logic [PRG_BANK_W+13:0]       prg_addr,
  input logic [CHR_BANK_W+9:0]        chr_addr,
  input logic                         nt_page,
  input logic [1:0]                   mode
);
  // R4
  fixed_bank_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[14] |=> prg_addr[PRG_BANK_W+13:14] == '1);

  // R5
  prg_offset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_addr[13:0] == $past(cpu_addr[13:0]));

  // R6
  chr_offset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chr_addr[9:0] == $past(ppu_addr[9:0]));

  // R3
  prg_bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15] && cpu_addr[3:0] == 4'd8) ##1 !cpu_addr[14]
      |=> prg_addr[PRG_BANK_W+13:14] == $past(cpu_data[PRG_BANK_W-1:0], 2));

  // R7
  nt_vert_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd0 |=> nt_page == $past(ppu_addr[10]));

  // R7
  nt_horz_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd1 |=> nt_page == $past(ppu_addr[11]));

  // R7
  nt_single_chk: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> nt_page == $past(mode[0]));
endmodule

bind cart_bank_map cart_bank_map_chk #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
  .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page),
  .mode(mode_q)
);

// File: tb/cart_bank_map_bench.sv
`timescale 1ns/1ps
module cart_bank_map_bench;
  localparam int PBW = 4;
  localparam int CBW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [PBW+13:0] prg_addr;
  logic [CBW+9:0]  chr_addr;
  logic            nt_page;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cart_bank_map #(.PRG_BANK_W(PBW), .CHR_BANK_W(CBW)) u_cart_bank_map (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_page(nt_page)
  );

  // behavioural reference model
  int m_chr[8];
  int m_prg;
  int m_mir;
  int e_prg, e_chr, e_nt;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_chr[i]) m_chr[i] = 0;
      m_prg = 0; m_mir = 0;
      e_prg = 0; e_chr = 0; e_nt = 0;
    end else begin
      int a, p, bank;
      a = int'(cpu_addr); p = int'(ppu_addr);
      bank = (a / 16384) % 2 == 1 ? (1 << PBW) - 1 : m_prg;
      e_prg = bank * 16384 + a % 16384;
      e_chr = m_chr[(p / 1024) % 8] * 1024 + p % 1024;
      case (m_mir)
        0: e_nt = (p / 1024) % 2;
        1: e_nt = (p / 2048) % 2;
        2: e_nt = 0;
        default: e_nt = 1;
      endcase
      if (cpu_wr && a >= 32768) begin
        if (a % 16 < 8)       m_chr[a % 16] = int'(cpu_data) % (1 << CBW);
        else if (a % 16 == 8) m_prg = int'(cpu_data) % (1 << PBW);
        else if (a % 16 == 9) m_mir = int'(cpu_data) % 4;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // model comparison on every clock, away from the active edge (R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 prg_addr vs model", int'(prg_addr), e_prg);
      check("R6 chr_addr vs model", int'(chr_addr), e_chr);
      check("R7 nt_page vs model", int'(nt_page), e_nt);
    end
  end

  task automatic step(bit wr, logic [15:0] a, logic [7:0] d, logic [13:0] p);
    cpu_wr = wr; cpu_addr = a; cpu_data = d; ppu_addr = p;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 16'h8008, 8'h0F, 14'h1FFF);
    step(1, 16'h8009, 8'h03, 14'h0C00);
    step(0, 16'hC000, 8'h00, 14'h0000);
    // R9: outputs held at zero in reset
    check("R9 prg_addr in reset", int'(prg_addr), 0);
    check("R9 chr_addr in reset", int'(chr_addr), 0);
    check("R9 nt_page in reset", int'(nt_page), 0);
    rst = 1'b0;
    step(0, 16'h8000, 8'h00, 14'h1C00);
    check("R9 slot 7 cleared", int'(chr_addr), 0);

    // R2 / R1: fill slots through mirrored addresses
    for (int i = 0; i < 8; i++)
      step(1, 16'hA5F0 | 16'(i), 8'(8'h11 * (i + 1)), 14'h0000);
    step(1, 16'hFFF3, 8'hA7, 14'h0000);
    step(0, 16'h0000, 8'h00, 14'h0C55);
    check("R2 slot 3 via mirror", int'(chr_addr), 'h29C55);
    step(0, 16'h0000, 8'h00, 14'h1E01);
    check("R6 slot 7", int'(chr_addr), 'h22201);

    // R3 / R5 / R4
    step(1, 16'h8008, 8'hF5, 14'h0000);
    step(0, 16'h8123, 8'h00, 14'h0000);
    check("R3 switchable window", int'(prg_addr), 'h14123);
    step(0, 16'hC456, 8'h00, 14'h0000);
    check("R4 fixed window", int'(prg_addr), 'h3C456);

    // R7 modes
    step(1, 16'hE009, 8'hFD, 14'h0000);
    step(0, 16'h0000, 8'h00, 14'h0800);
    check("R7 horizontal high", int'(nt_page), 1);
    step(0, 16'h0000, 8'h00, 14'h0400);
    check("R7 horizontal low", int'(nt_page), 0);
    step(1, 16'h8009, 8'h02, 14'h0C00);
    step(0, 16'h0000, 8'h00, 14'h0C00);
    check("R7 single page 0", int'(nt_page), 0);
    step(1, 16'h8009, 8'h03, 14'h0000);
    step(0, 16'h0000, 8'h00, 14'h0000);
    check("R7 single page 1", int'(nt_page), 1);
    step(1, 16'h8009, 8'h00, 14'h0000);
    step(0, 16'h0000, 8'h00, 14'h0400);
    check("R7 vertical", int'(nt_page), 1);

    // R8: ignored indices and low-half writes
    step(1, 16'h800C, 8'hFF, 14'h0000);
    step(1, 16'h0008, 8'h09, 14'h0000);
    step(1, 16'h7FF9, 8'h01, 14'h0000);
    step(1, 16'h800F, 8'hFF, 14'h0000);
    step(0, 16'h8000, 8'h00, 14'h0800);
    check("R8 prg bank kept", int'(prg_addr), 'h14000);
    check("R8 mode kept", int'(nt_page), 0);

    // R10: write and translation in the same cycle
    step(1, 16'h8008, 8'h07, 14'h0000);
    check("R10 old bank in write cycle", int'(prg_addr), 'h14008);
    step(0, 16'h8008, 8'h00, 14'h0000);
    check("R10 new bank next cycle", int'(prg_addr), 'h1C008);

    // random traffic judged by the model (R1 R2 R3 R8)
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 1) == 1, 16'($urandom), 8'($urandom), 14'($urandom));

    // mid-run reset (R9)
    rst = 1'b1;
    step(0, 16'h0000, 8'h00, 14'h0000);
    rst = 1'b0;
    step(0, 16'h8001, 8'h00, 14'h1FFF);
    check("R9 registers cleared", int'(prg_addr), 'h00001);
    check("R9 chr cleared", int'(chr_addr), 'h003FF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule